// File: doc/BRIEF.md
# Configuration Frame Scrubber with Fault Injection

The scrubber guards a small configuration store of 16 frames, each holding 32 data bits and a 16-bit check word. In configuration mode a loader writes frames through a valid/ready port, and the block computes and stores each frame's check word. In user mode the block sweeps the frames in a loop. It recomputes each frame's check word and compares it with the stored one. When scrubbing is on and a frame fails, the block finds the flipped bit, or pair of adjacent flipped bits, from the syndrome. It repairs the frame in place and checks it again. The design using the store is not stopped while this happens.

A small serial test port lets the checker be exercised. A 10-bit instruction register selects a 47-bit injection register, which is shifted in one bit at a time. An update pulse then arms a request that flips one bit, or two neighbouring bits, of frame 0. The error output always shows the result of the most recently completed frame check. A read port exposes the stored data so that injections and repairs can be observed.

Top module: `frame_scrubber`

## Requirements
- R1: While reset is low, and after it is released, crc_err, uncorr and frame_done are 0. With user_mode low, cfg_ready is 1.
- R2: cfg_ready equals !user_mode. A cycle with cfg_valid and cfg_ready high stores cfg_data into frame cfg_addr. If cfg_valid is held while cfg_ready is low, nothing is written, so a loader keeps its request until cfg_ready returns. rd_data shows frame rd_addr one cycle after rd_addr is presented.
- R3: In user mode the frames are checked in order 0,1,...,15,0,... The sweep restarts at frame 0 each time user_mode rises. frame_done is high for exactly one cycle per completed check, and frame_idx then names that frame.
- R4: The check word is a CRC-16 with polynomial 0x1021 and an all-zero initial value. It is shifted over data bits 31 down to 0. A frame whose data still matches its stored check word completes with crc_err low.
- R5: crc_err and uncorr change only in a cycle where frame_done is high, and otherwise hold the result of the last completed check.
- R6: Instruction code 10'b00_0001_0101 selects the injection register. The register is shifted LSB first from tst_tdi, 47 bits per request. Its fields are: bit 46 = request valid; bit 45 = 0 for a single flip or 1 for an adjacent pair; bits 44..40 = bit index; bits 39..0 must be zero.
- R7: A tst_update is ignored when user_mode is low, when any other instruction is loaded, or when reserved bits are nonzero.
- R8: An armed request flips only frame 0. It flips bit idx, or bits idx and idx+1 for a pair. A pair request with idx 31 is discarded without any flip. The request clears itself once taken, so it is applied exactly once.
- R9: With scrub_en low, a corrupted frame is left unchanged and reports crc_err high on every pass, while clean frames report crc_err low.
- R10: With scrub_en high, a single flipped bit in a frame is repaired in place, and the check of that frame completes with crc_err low.
- R11: With scrub_en high, a pair of adjacent flipped bits is repaired in place, and the check completes with crc_err low.
- R12: Candidate syndromes are tried in order: single bits 0..31, then pairs (0,1)..(30,31). If none matches, or the recheck after repair fails, the check completes with crc_err and uncorr high and the frame unchanged. uncorr is never high without crc_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| user_mode | input | 1 | 1 = user mode (sweep runs), 0 = configuration mode |
| scrub_en | input | 1 | Enables in-place repair |
| cfg_valid | input | 1 | Frame write request |
| cfg_ready | output | 1 | Write accepted this cycle when high with cfg_valid |
| cfg_addr | input | 4 | Frame number to write |
| cfg_data | input | 32 | Frame data to write |
| rd_addr | input | 4 | Frame number to read |
| rd_data | output | 32 | Stored data of rd_addr, one cycle later |
| tst_ir_wr | input | 1 | Loads tst_ir into the instruction register |
| tst_ir | input | 10 | Instruction code |
| tst_shift | input | 1 | Shifts tst_tdi into the injection shift register |
| tst_tdi | input | 1 | Serial data in |
| tst_update | input | 1 | Transfers the shift register into the injection register |
| crc_err | output | 1 | Last completed check failed |
| uncorr | output | 1 | Last completed check could not be repaired |
| frame_done | output | 1 | One-cycle strobe per completed check |
| frame_idx | output | 4 | Frame of the last completed check |

## Verification
Four properties are checked on every cycle: the single-cycle width of frame_done, that the status outputs move only on that strobe, that uncorr implies crc_err, and that completions follow ascending, wrapping frame order. Further properties check that the candidate counter stays in range, that an ignored update leaves the injection register alone, and that a taken request clears. Which bits an injection flips, that a repair restores the original data, and which triple-bit patterns end as uncorrectable can only be shown by the bench's scenarios, which compare read-back data against a CRC model of its own.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_CHECK,
    S_SEARCH,
    S_FIX,
    S_RECHK
  } scrub_state_e;
endpackage

// File: rtl/scrub_crc.sv
module scrub_crc #(
  parameter int DW = 32,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY = 16'h1021
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] crc
);
  // bit-serial CRC, MSB of data first, zero seed (linear in data)
  always_comb begin
    logic [CW-1:0] c;
    logic fb;
    c = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[CW-1] ^ data[i];
      c  = {c[CW-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc = c;
  end
endmodule

// File: rtl/scrub_store.sv
module scrub_store #(
  parameter int NFRAMES = 16,
  parameter int DW = 32,
  parameter int CW = 16,
  localparam int FAW = $clog2(NFRAMES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [FAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [CW-1:0]  wr_crc,
  input  logic           xw_en,
  input  logic [FAW-1:0] xw_addr,
  input  logic [DW-1:0]  xw_mask,
  input  logic [FAW-1:0] chk_addr,
  output logic [DW-1:0]  chk_data,
  output logic [CW-1:0]  chk_crc,
  input  logic [FAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data
);
  logic [DW-1:0] dat_q [NFRAMES];
  logic [CW-1:0] crc_q [NFRAMES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NFRAMES; f++) begin
        dat_q[f] <= '0;
        crc_q[f] <= '0;
      end
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        dat_q[wr_addr] <= wr_data;
        crc_q[wr_addr] <= wr_crc;
      end else if (xw_en) begin
        dat_q[xw_addr] <= dat_q[xw_addr] ^ xw_mask;
      end
      rd_data <= dat_q[rd_addr];
    end
  end

  assign chk_data = dat_q[chk_addr];
  assign chk_crc  = crc_q[chk_addr];

  // R2: loader writes and in-place flips never share a cycle
  p_write_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !xw_en);
endmodule

// File: rtl/scrub_inj.sv
module scrub_inj #(
  parameter int IRW = 10,
  parameter logic [IRW-1:0] IR_CODE = 10'b00_0001_0101,
  parameter int INJW = 47,
  parameter int DW = 32,
  localparam int BIW = $clog2(DW),
  localparam int RSVW = INJW - 2 - BIW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           user_mode,
  input  logic           ir_wr,
  input  logic [IRW-1:0] ir_in,
  input  logic           dr_shift,
  input  logic           dr_tdi,
  input  logic           dr_update,
  input  logic           apply,
  output logic           pend,
  output logic [DW-1:0]  mask
);
  logic [IRW-1:0]  ir_q;
  logic [INJW-1:0] sr_q;
  logic            vld_q;
  logic            dbl_q;
  logic [BIW-1:0]  idx_q;
  logic            take;

  assign take = dr_update && user_mode && (ir_q == IR_CODE) &&
                (sr_q[RSVW-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= '0;
      sr_q  <= '0;
      vld_q <= 1'b0;
      dbl_q <= 1'b0;
      idx_q <= '0;
    end else begin
      if (ir_wr) ir_q <= ir_in;
      if (dr_shift) sr_q <= {dr_tdi, sr_q[INJW-1:1]};
      if (take) begin
        vld_q <= sr_q[INJW-1];
        dbl_q <= sr_q[INJW-2];
        idx_q <= sr_q[INJW-3 -: BIW];
      end else if (apply) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign pend = vld_q;

  always_comb begin
    if (!dbl_q)
      mask = DW'(1) << idx_q;
    else if (idx_q != BIW'(DW - 1))
      mask = DW'(3) << idx_q;
    else
      mask = '0;
  end

  // R7: an update outside user mode leaves the armed request untouched
  p_update_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_update && !user_mode && !apply) |=> $stable(vld_q) && $stable(idx_q) && $stable(dbl_q));
  // R8: a taken request is consumed once
  p_request_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !dr_update) |=> !vld_q);
endmodule

// File: rtl/frame_scrubber.sv
module frame_scrubber #(
  parameter int NFRAMES = 16,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY = 16'h1021,
  parameter int IRW = 10,
  parameter logic [IRW-1:0] IR_CODE = 10'b00_0001_0101,
  parameter int INJW = 47,
  localparam int FAW = $clog2(NFRAMES),
  localparam int NCAND = 2 * DW - 1,
  localparam int CIW = $clog2(NCAND)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           user_mode,
  input  logic           scrub_en,
  input  logic           cfg_valid,
  output logic           cfg_ready,
  input  logic [FAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_data,
  input  logic [FAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           tst_ir_wr,
  input  logic [IRW-1:0] tst_ir,
  input  logic           tst_shift,
  input  logic           tst_tdi,
  input  logic           tst_update,
  output logic           crc_err,
  output logic           uncorr,
  output logic           frame_done,
  output logic [FAW-1:0] frame_idx
);
  import scrub_pkg::*;

  localparam logic [CIW-1:0] LAST_CAND = CIW'(NCAND - 1);
  localparam logic [FAW-1:0] LAST_FRM  = FAW'(NFRAMES - 1);

  scrub_state_e   state, state_n;
  logic [FAW-1:0] ptr;
  logic [CIW-1:0] cand;
  logic [CW-1:0]  syn_q, syndrome;
  logic [DW-1:0]  pat, pat_q;
  logic [DW-1:0]  chk_data;
  logic [CW-1:0]  chk_crc, calc_crc, pat_crc, wr_crc;
  logic           wr_en;
  logic           xw_en;
  logic [FAW-1:0] xw_addr;
  logic [DW-1:0]  xw_mask;
  logic           inj_pend, inj_apply;
  logic [DW-1:0]  inj_mask;
  logic           fin, fin_err, fin_unc, load_syn, cand_inc, take_pat;
  logic           err_q, unc_q, done_q;
  logic [FAW-1:0] idx_q;

  assign cfg_ready = !user_mode;
  assign wr_en     = cfg_valid && cfg_ready;

  scrub_crc #(.DW(DW), .CW(CW), .POLY(POLY)) u_crc_wr  (.data(cfg_data), .crc(wr_crc));
  scrub_crc #(.DW(DW), .CW(CW), .POLY(POLY)) u_crc_chk (.data(chk_data), .crc(calc_crc));
  scrub_crc #(.DW(DW), .CW(CW), .POLY(POLY)) u_crc_pat (.data(pat),      .crc(pat_crc));

  scrub_store #(.NFRAMES(NFRAMES), .DW(DW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(cfg_addr), .wr_data(cfg_data), .wr_crc(wr_crc),
    .xw_en(xw_en), .xw_addr(xw_addr), .xw_mask(xw_mask),
    .chk_addr(ptr), .chk_data(chk_data), .chk_crc(chk_crc),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  scrub_inj #(.IRW(IRW), .IR_CODE(IR_CODE), .INJW(INJW), .DW(DW)) u_inj (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
    .ir_wr(tst_ir_wr), .ir_in(tst_ir),
    .dr_shift(tst_shift), .dr_tdi(tst_tdi), .dr_update(tst_update),
    .apply(inj_apply), .pend(inj_pend), .mask(inj_mask)
  );

  assign syndrome = calc_crc ^ chk_crc;

  // candidate error pattern: singles first, then adjacent pairs
  always_comb begin
    if (cand < CIW'(DW))
      pat = DW'(1) << cand;
    else
      pat = DW'(3) << (cand - CIW'(DW));
  end

  always_comb begin
    state_n   = state;
    fin       = 1'b0;
    fin_err   = 1'b0;
    fin_unc   = 1'b0;
    load_syn  = 1'b0;
    cand_inc  = 1'b0;
    take_pat  = 1'b0;
    xw_en     = 1'b0;
    xw_addr   = ptr;
    xw_mask   = pat_q;
    inj_apply = 1'b0;
    if (!user_mode) begin
      state_n = S_IDLE;
    end else begin
      case (state)
        S_IDLE: state_n = S_START;
        S_START: begin
          if (inj_pend) begin
            inj_apply = 1'b1;
            xw_en     = 1'b1;
            xw_addr   = '0;
            xw_mask   = inj_mask;
          end else begin
            state_n = S_CHECK;
          end
        end
        S_CHECK: begin
          if (syndrome == '0) begin
            fin = 1'b1;
          end else if (scrub_en) begin
            load_syn = 1'b1;
            state_n  = S_SEARCH;
          end else begin
            fin     = 1'b1;
            fin_err = 1'b1;
          end
        end
        S_SEARCH: begin
          if (pat_crc == syn_q) begin
            take_pat = 1'b1;
            state_n  = S_FIX;
          end else if (cand == LAST_CAND) begin
            fin     = 1'b1;
            fin_err = 1'b1;
            fin_unc = 1'b1;
          end else begin
            cand_inc = 1'b1;
          end
        end
        S_FIX: begin
          xw_en   = 1'b1;
          state_n = S_RECHK;
        end
        S_RECHK: begin
          fin     = 1'b1;
          fin_err = (syndrome != '0);
          fin_unc = (syndrome != '0);
        end
        default: state_n = S_IDLE;
      endcase
      if (fin) state_n = S_START;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ptr    <= '0;
      cand   <= '0;
      syn_q  <= '0;
      pat_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unc_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      state  <= state_n;
      done_q <= fin;
      if (load_syn) begin
        syn_q <= syndrome;
        cand  <= '0;
      end else if (cand_inc) begin
        cand <= cand + 1'b1;
      end
      if (take_pat) pat_q <= pat;
      if (fin) begin
        err_q <= fin_err;
        unc_q <= fin_unc;
        idx_q <= ptr;
        ptr   <= (ptr == LAST_FRM) ? '0 : ptr + 1'b1;
      end
      if (!user_mode) ptr <= '0;
    end
  end

  assign crc_err    = err_q;
  assign uncorr     = unc_q;
  assign frame_done = done_q;
  assign frame_idx  = idx_q;

  // expected-order tracker for the sweep property
  logic [FAW-1:0] exp_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_idx <= '0;
    else if (!user_mode) exp_idx <= '0;
    else if (frame_done) exp_idx <= (exp_idx == LAST_FRM) ? '0 : exp_idx + 1'b1;
  end

  // R3: completion strobe lasts one cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R3: completions come in ascending, wrapping frame order
  p_sweep_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_idx == exp_idx);
  // R5: status only moves together with the strobe
  p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(crc_err) || !$stable(uncorr)) |-> frame_done);
  // R12: uncorrectable always reported as an error
  p_unc_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |-> crc_err);
  // R12: candidate search stays within the pattern list
  p_cand_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEARCH) |-> cand <= LAST_CAND);
  // R10: a repair write is only reached from a syndrome match
  p_fix_from_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIX) |-> $past(state) == S_SEARCH);
endmodule

// File: tb/frame_scrubber_tb.sv
module frame_scrubber_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        user_mode = 1'b0, scrub_en = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tst_ir_wr = 1'b0;
  logic [9:0]  tst_ir = '0;
  logic        tst_shift = 1'b0, tst_tdi = 1'b0, tst_update = 1'b0;
  logic        crc_err, uncorr, frame_done;
  logic [3:0]  frame_idx;

  int checks = 0;
  int errors = 0;
  logic [31:0] gold [16];

  always #10 clk = ~clk;

  frame_scrubber u_dut (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .scrub_en(scrub_en),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tst_ir_wr(tst_ir_wr), .tst_ir(tst_ir), .tst_shift(tst_shift), .tst_tdi(tst_tdi),
    .tst_update(tst_update),
    .crc_err(crc_err), .uncorr(uncorr), .frame_done(frame_done), .frame_idx(frame_idx)
  );

  // {pair, index, expected flip mask}
  localparam logic [37:0] VEC [7] = '{
    {1'b0, 5'd0,  32'h0000_0001},
    {1'b0, 5'd31, 32'h8000_0000},
    {1'b0, 5'd13, 32'h0000_2000},
    {1'b1, 5'd0,  32'h0000_0003},
    {1'b1, 5'd30, 32'hC000_0000},
    {1'b1, 5'd7,  32'h0000_0180},
    {1'b1, 5'd31, 32'h0000_0000}
  };

  function automatic logic [15:0] crc16(input logic [31:0] d);
    logic [15:0] c = '0;
    for (int i = 31; i >= 0; i--) begin
      if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
      else c = {c[14:0], 1'b0};
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input int fidx);
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (frame_done && frame_idx == 4'(fidx)) return;
    end
    chk("R3 timeout waiting for frame", 32'(frame_idx), 32'(fidx));
  endtask

  task automatic read_frame(input int f, output logic [31:0] v);
    @(negedge clk);
    rd_addr = 4'(f);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic send_inj(input logic [9:0] code, input logic [46:0] w);
    @(negedge clk);
    tst_ir_wr = 1'b1; tst_ir = code;
    @(negedge clk);
    tst_ir_wr = 1'b0; tst_shift = 1'b1;
    for (int i = 0; i < 47; i++) begin
      tst_tdi = w[i];
      @(negedge clk);
    end
    tst_shift = 1'b0; tst_update = 1'b1;
    @(negedge clk);
    tst_update = 1'b0;
  endtask

  function automatic logic [46:0] req(input logic dbl, input logic [4:0] idx);
    logic [46:0] w = '0;
    w[46] = 1'b1; w[45] = dbl; w[44:40] = idx;
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] tri_exp;
    logic        alias_hit;
    logic [31:0] alias_pat;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 crc_err in reset", 32'(crc_err), 0);
    chk("R1 frame_done in reset", 32'(frame_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 uncorr after reset", 32'(uncorr), 0);
    chk("R1 cfg_ready in config mode", 32'(cfg_ready), 1);

    // R2 loading all frames
    for (int f = 0; f < 16; f++) begin
      gold[f] = 32'h3C5A_96E1 ^ (32'(f) * 32'h0101_1011);
      cfg_valid = 1'b1; cfg_addr = 4'(f); cfg_data = gold[f];
      @(negedge clk);
    end
    cfg_valid = 1'b0;
    read_frame(5, v);  chk("R2 readback frame 5", v, gold[5]);
    read_frame(15, v); chk("R2 readback frame 15", v, gold[15]);

    // R3/R4 clean sweep in order
    user_mode = 1'b1;
    @(negedge clk);
    chk("R2 cfg_ready low in user mode", 32'(cfg_ready), 0);
    cfg_valid = 1'b1; cfg_addr = 4'd3; cfg_data = 32'hDEAD_BEEF;
    @(negedge clk);
    cfg_valid = 1'b0;
    read_frame(3, v); chk("R2 write ignored while not ready", v, gold[3]);
    for (int k = 0; k < 18; k++) begin
      wait_done(k % 16);
      chk("R4 clean frame passes", 32'(crc_err), 0);
      @(negedge clk);
      chk("R3 strobe one cycle", 32'(frame_done), 0);
    end

    // R7 injection ignored outside user mode
    user_mode = 1'b0;
    send_inj(10'b00_0001_0101, req(1'b0, 5'd4));
    user_mode = 1'b1;
    wait_done(0); wait_done(0);
    chk("R7 config-mode update ignored", 32'(crc_err), 0);
    // R7 wrong instruction code, reserved bits nonzero
    send_inj(10'b00_0001_0110, req(1'b0, 5'd4));
    wait_done(0); wait_done(0);
    chk("R7 other instruction ignored", 32'(crc_err), 0);
    send_inj(10'b00_0001_0101, req(1'b0, 5'd4) | 47'h1);
    wait_done(0); wait_done(0);
    chk("R7 reserved bits nonzero ignored", 32'(crc_err), 0);
    read_frame(0, v); chk("R7 frame 0 untouched", v, gold[0]);

    // R6/R8/R9/R10/R11 table walk
    foreach (VEC[i]) begin
      scrub_en = 1'b0;
      send_inj(10'b00_0001_0101, req(VEC[i][37], VEC[i][36:32]));
      wait_done(0); wait_done(0);
      chk("R9 frame 0 status with scrub off", 32'(crc_err), 32'(VEC[i][31:0] != 0));
      read_frame(0, v);
      chk("R8 R6 injected flip pattern, applied once", v, gold[0] ^ VEC[i][31:0]);
      wait_done(1);
      chk("R9 clean frame 1 clears status", 32'(crc_err), 0);
      scrub_en = 1'b1;
      wait_done(0); wait_done(0);
      chk(VEC[i][37] ? "R11 pair repaired status" : "R10 single repaired status",
          32'(crc_err), 0);
      chk("R12 no uncorrectable on repair", 32'(uncorr), 0);
      read_frame(0, v);
      chk(VEC[i][37] ? "R11 pair repaired data" : "R10 single repaired data", v, gold[0]);
    end

    // R12 three flipped bits
    scrub_en = 1'b0;
    for (int b = 0; b < 3; b++) begin
      send_inj(10'b00_0001_0101, req(1'b0, 5'(b)));
      wait_done(0); wait_done(0);
    end
    read_frame(0, v); chk("R8 three singles accumulate", v, gold[0] ^ 32'h7);
    alias_hit = 1'b0; alias_pat = '0;
    for (int k = 0; k < 63; k++) begin
      logic [31:0] p;
      p = (k < 32) ? (32'h1 << k) : (32'h3 << (k - 32));
      if (!alias_hit && crc16(p) == crc16(32'h7)) begin
        alias_hit = 1'b1; alias_pat = p;
      end
    end
    tri_exp = alias_hit ? (gold[0] ^ 32'h7 ^ alias_pat) : (gold[0] ^ 32'h7);
    scrub_en = 1'b1;
    wait_done(0); wait_done(0);
    chk("R12 error flag on triple", 32'(crc_err), 32'(!alias_hit));
    chk("R12 uncorrectable flag on triple", 32'(uncorr), 32'(!alias_hit));
    read_frame(0, v); chk("R12 frame contents after search", v, tri_exp);
    wait_done(1);
    chk("R5 status follows next frame", 32'(uncorr), 0);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 crc_err cleared by reset", 32'(crc_err), 0);
    chk("R1 frame_done low in reset", 32'(frame_done), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule